// File: doc/BRIEF.md
# Runtime-Formatted Asynchronous Serial Transmitter

This block turns parallel characters into a start-stop serial stream on one output line. A host hands over characters through a valid/ready write port into a single-entry holding register. A separate shift register sends the current character. The host can therefore load the next character while the current one is still going out, and consecutive characters leave with no idle time between them. The line rests at logic 1. Bit timing comes from an external enable pulse, `baud_tick`, which runs at OVS times the bit rate.

The character format is chosen at run time by plain configuration pins:
- 7 or 8 data bits;
- no parity, even parity or odd parity;
- 1 or 2 stop bits;
- an optional multiprocessor bit that marks a character as an ID (1) or as data (0).

The format is taken from the pins at the moment a character moves from the holding register into the shift register. Two status pins are provided. `buf_empty` reports that the holding register can take a character. `tx_end` reports that everything has been sent.

Back-pressure rules: a transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low whenever the holding register is occupied. While `in_valid` is high and `in_ready` is low, the host keeps `in_data` and `in_mpb` stable. A character is never dropped and never duplicated.

Top module: `mpx_uart_tx`

## Requirements
- R1: After reset, `txd`=1, `in_ready`=1, `buf_empty`=1 and `tx_end`=1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` and `buf_empty` are 0 from the next cycle until that character moves into the shift register.
- R3: A frame is a start bit of 0, then the data bits least significant first, then the optional extra bit, then the stop bits of 1. Each bit lasts exactly OVS `baud_tick` pulses. `txd` changes only on a tick that ends a bit, or on the clock edge that loads a new character into an idle shifter.
- R4: With `cfg_len7`=1, only `in_data[6:0]` is sent (7 data bits). With `cfg_len7`=0, all 8 bits are sent.
- R5: `cfg_parity` selects the parity bit placed after the data bits: 2'b01 gives even parity (the data ones plus the parity bit make an even count), 2'b10 gives odd parity, and 2'b00 or 2'b11 sends no parity bit.
- R6: With `cfg_mp_en`=1, the bit `in_mpb` taken with the character is sent right after the data bits, and no parity bit is sent whatever `cfg_parity` holds.
- R7: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R8: If the holding register is full when the last stop bit ends, the next start bit begins on the very next cycle, with no idle-high period between the frames.
- R9: `tx_end` is 1 exactly when the shifter has finished its last stop bit and the holding register is empty.
- R10: The format pins are applied to a character when it moves into the shift register. Changing them while a frame is being sent does not alter that frame.
- R11: While no frame is being sent, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Enable pulse at OVS times the bit rate |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_parity | input | 2 | 01 even, 10 odd, 00/11 none |
| cfg_mp_en | input | 1 | Send the multiprocessor bit instead of parity |
| in_valid | input | 1 | Write port: character offered |
| in_ready | output | 1 | Write port: holding register free |
| in_data | input | DATA_W | Character to send |
| in_mpb | input | 1 | Multiprocessor bit for this character (1 = ID) |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register is empty |
| tx_end | output | 1 | All characters have been sent |

## Verification
The bench builds the block with its default values: DATA_W = 8 and OVS = 16. This gives 12-bit frames at the widest format (8 data bits, an extra bit and 2 stop bits), so every format combination can be reached.

The bench varies the tick spacing between every cycle and every third cycle. This shows that bit length follows the tick count and not the clock. Streaming runs with `in_valid` held high exercise back-pressure and the gap-free hand-off. A format change in the middle of a frame shows that the format is captured when a character is loaded.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_t;

  function automatic logic par_active(input par_mode_t m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] q_data,
  output logic              q_mpb
);
  logic accept;
  assign wr_ready = !full;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      q_data <= '0;
      q_mpb  <= 1'b0;
    end else if (accept) begin
      full   <= 1'b1;
      q_data <= wr_data;
      q_mpb  <= wr_mpb;
    end else if (take) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               mpb,
  input  logic               len7,
  input  logic               stop2,
  input  par_mode_t          pmode,
  input  logic               mp_en,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [DATA_W-1:0] dmask;
  logic [DATA_W-1:0] dsel;
  logic              pbit;
  logic              extra_on;
  logic              extra_val;
  logic [CNT_W-1:0]  pos;

  always_comb begin
    dmask = '1;
    if (len7) dmask[DATA_W-1] = 1'b0;
    dsel      = data & dmask;
    pbit      = (pmode == PAR_ODD) ? ~(^dsel) : (^dsel);
    extra_on  = mp_en || par_active(pmode);
    extra_val = mp_en ? mpb : pbit;
  end

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (!(len7 && i == DATA_W - 1)) frame[1+i] = data[i];
    end
    pos = CNT_W'(len7 ? DATA_W : DATA_W + 1);
    if (extra_on) frame[pos] = extra_val;
    nbits = pos + CNT_W'(extra_on) + CNT_W'(stop2 ? 2 : 1);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int OVS     = 16,
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1),
  parameter int TCK_W   = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               pending,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               take,
  output logic               busy,
  output logic               txd
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic [TCK_W-1:0]   tcnt;
  logic               bit_end;
  logic               last_bit;

  assign bit_end  = busy && tick && (tcnt == TCK_W'(OVS - 1));
  assign last_bit = (left == CNT_W'(1));
  assign take     = pending && (!busy || (bit_end && last_bit));
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sh   <= frame;
      left <= nbits;
      tcnt <= '0;
      busy <= 1'b1;
    end else if (bit_end) begin
      tcnt <= '0;
      if (last_bit) begin
        busy <= 1'b0;
        sh   <= '1;
        left <= '0;
      end else begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end else if (busy && tick) begin
      tcnt <= tcnt + TCK_W'(1);
    end
  end
endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_len7,
  input  logic              cfg_stop2,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_mp_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mpb,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_end
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_mpb;
  logic               take;
  logic               sh_busy;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  par_mode_t          pmode;

  assign pmode = par_mode_t'(cfg_parity);

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready),
    .wr_data(in_data), .wr_mpb(in_mpb),
    .take(take), .full(hold_full),
    .q_data(hold_data), .q_mpb(hold_mpb)
  );

  sertx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data(hold_data), .mpb(hold_mpb),
    .len7(cfg_len7), .stop2(cfg_stop2),
    .pmode(pmode), .mp_en(cfg_mp_en),
    .frame(frame), .nbits(nbits)
  );

  sertx_shift #(.OVS(OVS), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .pending(hold_full), .frame(frame), .nbits(nbits),
    .take(take), .busy(sh_busy), .txd(txd)
  );

  assign buf_empty = !hold_full;
  assign tx_end    = !hold_full && !sh_busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic buf_empty,
  input logic tx_end,
  input logic txd,
  input logic busy
);
  AST_READY_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == buf_empty); // R2
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !buf_empty); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R3
  AST_TXD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(baud_tick)) |-> $stable(txd)); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R11
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> (buf_empty && !busy)); // R9
endmodule

bind mpx_uart_tx sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
  .in_valid(in_valid), .in_ready(in_ready), .buf_empty(buf_empty),
  .tx_end(tx_end), .txd(txd), .busy(sh_busy)
);

// File: tb/sim_mpx_uart_tx.sv
`timescale 1ns/1ps
module sim_mpx_uart_tx;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       baud_tick = 0;
  logic       cfg_len7 = 0, cfg_stop2 = 0, cfg_mp_en = 0;
  logic [1:0] cfg_parity = 2'b00;
  logic       in_valid = 0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_mpb = 0;
  logic       txd, buf_empty, tx_end;

  int checks = 0, errors = 0, cycles = 0, tick_div = 1, tick_cnt = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mpx_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity),
    .cfg_mp_en(cfg_mp_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mpb(in_mpb), .txd(txd),
    .buf_empty(buf_empty), .tx_end(tx_end)
  );

  // Behavioural reference: a queue of pending line levels
  bit   m_bits[$];
  bit   m_full = 0;
  bit [7:0] m_data;
  bit   m_mpb;
  int   m_cnt = 0;

  task automatic build_frame();
    int dl, ones;
    dl = cfg_len7 ? 7 : 8;
    ones = 0;
    m_bits.push_back(1'b0);
    for (int i = 0; i < dl; i++) begin
      m_bits.push_back(m_data[i]);
      ones += m_data[i];
    end
    if (cfg_mp_en) m_bits.push_back(m_mpb);
    else if (cfg_parity == 2'b01) m_bits.push_back(ones % 2 == 1);
    else if (cfg_parity == 2'b10) m_bits.push_back(ones % 2 == 0);
    m_bits.push_back(1'b1);
    if (cfg_stop2) m_bits.push_back(1'b1);
    m_full = 0;
    m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      acc = in_valid && !m_full;
      if (m_bits.size() == 0) begin
        if (m_full) build_frame();
      end else if (baud_tick) begin
        if (m_cnt == 15) begin
          m_cnt = 0;
          void'(m_bits.pop_front());
          if (m_bits.size() == 0 && m_full) build_frame();
        end else m_cnt++;
      end
      if (acc) begin
        m_full = 1; m_data = in_data; m_mpb = in_mpb;
      end
      cycles++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "txd", txd, m_bits.size() ? m_bits[0] : 1);
      check("R2", "in_ready", in_ready, !m_full);
      check("R2", "buf_empty", buf_empty, !m_full);
      check("R9", "tx_end", tx_end, (m_bits.size() == 0) && !m_full);
    end
    tick_cnt = (tick_cnt + 1) % tick_div;
    baud_tick = (tick_cnt == 0);
  end

  task automatic send(bit [7:0] d, bit mp);
    in_valid = 1; in_data = d; in_mpb = mp;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_done();
    while (!tx_end) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R11", "idle line", txd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "txd", txd, 1);
    check("R1", "in_ready", in_ready, 1);
    check("R1", "buf_empty", buf_empty, 1);
    check("R1", "tx_end", tx_end, 1);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R3";                         // 8 data, no parity, 1 stop
    send(8'hA5, 0); wait_done();

    cur_req = "R4";                         // 7 data, even parity
    cfg_len7 = 1; cfg_parity = 2'b01;
    send(8'hBC, 0); send(8'h7F, 0); wait_done();

    cur_req = "R7";                         // 8 data, odd parity, 2 stop
    cfg_len7 = 0; cfg_parity = 2'b10; cfg_stop2 = 1;
    send(8'h00, 0); send(8'hFF, 0); wait_done();

    cur_req = "R6";                         // multiprocessor, parity ignored
    tick_div = 3; cfg_mp_en = 1; cfg_parity = 2'b01; cfg_stop2 = 0;
    send(8'h41, 1); send(8'h13, 0); wait_done();

    cur_req = "R5";                         // mode 11 means no parity
    tick_div = 1; cfg_mp_en = 0; cfg_parity = 2'b11;
    send(8'h96, 0); wait_done();

    cur_req = "R10";                        // change format mid frame
    cfg_parity = 2'b00;
    send(8'h5A, 0);
    repeat (40) @(negedge clk);
    cfg_parity = 2'b01; cfg_stop2 = 1; cfg_len7 = 1;
    wait_done();

    cur_req = "R8";                         // streaming, no gap
    cfg_parity = 2'b10; cfg_stop2 = 0; cfg_len7 = 0;
    for (int k = 0; k < 4; k++) send(8'(8'h11 * (k + 3)), 0);
    wait_done();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule